// File: doc/BRIEF.md
# Receive Scatter-Gather Descriptor Walker

This block sequences the receive side of a scatter-gather DMA channel. When a packet arrives, it walks a linked list of descriptors held in memory. For each descriptor it fetches the status, control, buffer-address and next-pointer words through a single-beat word-wide memory port. It then writes the packet's payload bytes one at a time into that descriptor's buffer, clipping the count to whatever remains of the packet, and writes back an updated status word. The walk continues along the next pointers until the packet is used up or the tail descriptor has been handled. A descriptor that is already marked complete halts the walk before anything is written.

Five 32-bit user words arrive on a separate side channel ahead of the packet and are held until needed. They are copied into the application area of the descriptor that receives the packet's final byte. The surrounding register file supplies the run/idle state and the current and tail pointers. It takes back the advanced current pointer, set pulses for its halted and idle flags, a frame-complete pulse for the interrupt coalescer, and the number of bytes accepted.

Descriptor layout, as byte offsets from the descriptor address, all little-endian:

| Offset | Contents |
| --- | --- |
| 0 | next pointer, low word (the high word is ignored) |
| 8 | buffer address, low word |
| 24 | control |
| 28 | status |
| 32 to 51 | five application words |

Addresses are `AW` bits wide.

Top module: `sg_rx_walker`

## Requirements
- R1: After reset, mem_req, busy, xfer_done, frame_done, halt_set, idle_set and uw_err are all 0.
- R2: A pkt_start while chan_run is 0, while chan_idle is 1, or with pkt_len 0 makes no memory request. The cycle after the start it raises xfer_done with xfer_bytes 0.
- R3: If a fetched status word has bit 31 (complete) set, halt_set pulses together with xfer_done. That descriptor is not written and cur_ptr_o stays on it.
- R4: Each descriptor receives min(buffer length, remaining packet bytes) payload bytes, in packet order, starting at its buffer address. No byte past that count is written. A byte is popped from in_byte only when its memory write is acknowledged.
- R5: The written-back status keeps the fetched status bits and sets bit 31 (complete). Bit 27 (start of frame) is set only on the packet's first descriptor. Bit 26 (end of frame) is set only on the descriptor that took the last byte.
- R6: The descriptor that took the last byte gets the five captured user words at offsets 32, 36, 40, 44 and 48.
- R7: After each write-back, cur_ptr_o becomes that descriptor's next pointer. If the descriptor was the tail, idle_set pulses together with xfer_done and the walk stops. halt_set and idle_set never pulse together.
- R8: frame_done pulses for exactly one cycle per packet, and only when the packet's final byte is written.
- R9: When xfer_done is high, xfer_bytes equals the number of payload bytes written. Bytes left over after an early stop are not counted.
- R10: A side-channel burst ending in uw_last must hold exactly five words to replace the captured words. Any other count pulses uw_err in the next cycle and leaves the captured words unchanged.
- R11: Only control bits [22:0] give the buffer length. Set bits 23, 26 and 27 do not change the count.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| chan_run | input | 1 | channel running |
| chan_idle | input | 1 | channel idle flag |
| cur_ptr_i | input | AW | first descriptor address |
| tail_ptr_i | input | AW | tail descriptor address |
| pkt_start | input | 1 | start a packet walk |
| pkt_len | input | PW | packet length in bytes |
| in_byte | input | 8 | current payload byte |
| in_pop | output | 1 | payload byte consumed |
| uw_valid | input | 1 | side-channel word valid |
| uw_data | input | 32 | side-channel word |
| uw_last | input | 1 | last word of side-channel burst |
| uw_err | output | 1 | wrong side-channel word count |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | request is a write |
| mem_addr | output | AW | word-aligned byte address |
| mem_be | output | 4 | byte enables for writes |
| mem_wdata | output | 32 | write data |
| mem_ack | input | 1 | request completed |
| mem_rdata | input | 32 | read data, valid with mem_ack |
| cur_ptr_o | output | AW | updated current pointer |
| busy | output | 1 | walk in progress |
| halt_set | output | 1 | set halted flag |
| idle_set | output | 1 | set idle flag |
| frame_done | output | 1 | completion event to coalescer |
| xfer_done | output | 1 | walk finished |
| xfer_bytes | output | PW | bytes accepted, valid with xfer_done |

## Verification
A refused start shows xfer_done in the cycle after the edge that samples pkt_start. halt_set and idle_set are due in the same cycle as xfer_done. frame_done is due in the cycle after the acknowledge of the final payload byte, and uw_err in the cycle after the edge that takes the last side-channel word. The bench drives at falling edges and samples every pulse at the falling edge that follows each rising edge. Pulses are counted over a whole walk, so a pulse that is missing, doubled or late is caught. Memory contents are compared only after xfer_done.

// File: rtl/sg_rx_walker.sv
module sg_rx_walker #(
  parameter int AW = 32,
  parameter int PW = 16,
  parameter int NUW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_run,
  input  logic          chan_idle,
  input  logic [AW-1:0] cur_ptr_i,
  input  logic [AW-1:0] tail_ptr_i,
  input  logic          pkt_start,
  input  logic [PW-1:0] pkt_len,
  input  logic [7:0]    in_byte,
  output logic          in_pop,
  input  logic          uw_valid,
  input  logic [31:0]   uw_data,
  input  logic          uw_last,
  output logic          uw_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] cur_ptr_o,
  output logic          busy,
  output logic          halt_set,
  output logic          idle_set,
  output logic          frame_done,
  output logic          xfer_done,
  output logic [PW-1:0] xfer_bytes
);
  localparam int LENW = 23;
  localparam int UIW = $clog2(NUW + 2);
  localparam logic [AW-1:0] OFF_BUF  = AW'(8);
  localparam logic [AW-1:0] OFF_CTRL = AW'(24);
  localparam logic [AW-1:0] OFF_STAT = AW'(28);
  localparam logic [AW-1:0] OFF_APP  = AW'(32);

  typedef enum logic [3:0] {
    S_IDLE, S_STAT, S_CTRL, S_BUF, S_NEXT, S_DATA, S_APP, S_WSTAT, S_ADV, S_FIN
  } st_t;

  st_t            state;
  logic [AW-1:0]  cur, tail, nxt, bufa;
  logic [PW-1:0]  rem, acc, chunk;
  logic [31:0]    stat_w;
  logic           first;
  logic [UIW-1:0] aidx;
  logic [UIW-1:0] ucnt;
  logic [31:0]    app_w  [NUW];
  logic [31:0]    shadow [NUW];

  wire [LENW-1:0] ctl_len = mem_rdata[LENW-1:0];
  wire [LENW-1:0] rem_x   = LENW'(rem);
  wire [PW-1:0]   clip    = (ctl_len < rem_x) ? PW'(ctl_len) : rem;
  wire            ack     = mem_req && mem_ack;

  assign busy       = state != S_IDLE;
  assign xfer_done  = state == S_FIN;
  assign xfer_bytes = acc;
  assign cur_ptr_o  = cur;
  assign mem_req    = state inside {S_STAT, S_CTRL, S_BUF, S_NEXT, S_DATA, S_APP, S_WSTAT};
  assign mem_we     = state inside {S_DATA, S_APP, S_WSTAT};
  assign in_pop     = (state == S_DATA) && mem_ack;

  always_comb begin
    mem_addr  = cur;
    mem_be    = 4'hF;
    mem_wdata = '0;
    case (state)
      S_STAT:  mem_addr = cur + OFF_STAT;
      S_CTRL:  mem_addr = cur + OFF_CTRL;
      S_BUF:   mem_addr = cur + OFF_BUF;
      S_NEXT:  mem_addr = cur;
      S_DATA: begin
        mem_addr  = {bufa[AW-1:2], 2'b00};
        mem_be    = 4'b0001 << bufa[1:0];
        mem_wdata = {4{in_byte}};
      end
      S_APP: begin
        mem_addr  = cur + OFF_APP + AW'({aidx, 2'b00});
        mem_wdata = app_w[aidx];
      end
      S_WSTAT: begin
        mem_addr  = cur + OFF_STAT;
        mem_wdata = stat_w | 32'h8000_0000 | ({31'd0, first} << 27)
                  | ({31'd0, rem == '0} << 26);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur        <= '0;
      tail       <= '0;
      nxt        <= '0;
      bufa       <= '0;
      rem        <= '0;
      acc        <= '0;
      chunk      <= '0;
      stat_w     <= '0;
      first      <= 1'b0;
      aidx       <= '0;
      halt_set   <= 1'b0;
      idle_set   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      halt_set   <= 1'b0;
      idle_set   <= 1'b0;
      frame_done <= 1'b0;
      case (state)
        S_IDLE:
          if (pkt_start) begin
            acc   <= '0;
            first <= 1'b1;
            rem   <= pkt_len;
            if (chan_run && !chan_idle && pkt_len != '0) begin
              cur   <= cur_ptr_i;
              tail  <= tail_ptr_i;
              state <= S_STAT;
            end else begin
              state <= S_FIN;
            end
          end
        S_STAT:
          if (ack) begin
            if (mem_rdata[31]) begin
              halt_set <= 1'b1;
              state    <= S_FIN;
            end else begin
              stat_w <= mem_rdata;
              state  <= S_CTRL;
            end
          end
        S_CTRL:
          if (ack) begin
            chunk <= clip;
            state <= S_BUF;
          end
        S_BUF:
          if (ack) begin
            bufa  <= mem_rdata[AW-1:0];
            state <= S_NEXT;
          end
        S_NEXT:
          if (ack) begin
            nxt   <= mem_rdata[AW-1:0];
            state <= (chunk != '0) ? S_DATA : S_WSTAT;
          end
        S_DATA:
          if (ack) begin
            bufa  <= bufa + AW'(1);
            chunk <= chunk - PW'(1);
            rem   <= rem - PW'(1);
            acc   <= acc + PW'(1);
            if (chunk == PW'(1)) begin
              if (rem == PW'(1)) begin
                frame_done <= 1'b1;
                aidx       <= '0;
                state      <= S_APP;
              end else begin
                state <= S_WSTAT;
              end
            end
          end
        S_APP:
          if (ack) begin
            aidx <= aidx + UIW'(1);
            if (aidx == UIW'(NUW - 1)) state <= S_WSTAT;
          end
        S_WSTAT:
          if (ack) state <= S_ADV;
        S_ADV: begin
          first <= 1'b0;
          cur   <= nxt;
          if (cur == tail) begin
            idle_set <= 1'b1;
            state    <= S_FIN;
          end else if (rem == '0) begin
            state <= S_FIN;
          end else begin
            state <= S_STAT;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  wire burst_end = uw_valid && uw_last;
  wire burst_ok  = ucnt == UIW'(NUW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucnt   <= '0;
      uw_err <= 1'b0;
    end else begin
      uw_err <= burst_end && !burst_ok;
      if (burst_end)     ucnt <= '0;
      else if (uw_valid) ucnt <= (ucnt == '1) ? ucnt : ucnt + UIW'(1);
    end
  end

  for (genvar k = 0; k < NUW; k++) begin : g_uw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[k] <= '0;
        app_w[k]  <= '0;
      end else begin
        if (uw_valid && ucnt == UIW'(k)) shadow[k] <= uw_data;
        if (burst_end && burst_ok)
          app_w[k] <= (k == NUW - 1) ? uw_data : shadow[k];
      end
    end
  end
endmodule

// File: rtl/sg_rx_walker_chk.sv
module sg_rx_walker_chk #(
  parameter int AW = 32,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_run,
  input logic          chan_idle,
  input logic          pkt_start,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          in_pop,
  input logic          halt_set,
  input logic          idle_set,
  input logic          frame_done,
  input logic          xfer_done,
  input logic [PW-1:0] xfer_bytes
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_pop_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> mem_req && mem_we && mem_ack);

  assert_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start && !busy && (!chan_run || chan_idle) |=> xfer_done && xfer_bytes == '0);

  assert_halt_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_set |-> xfer_done && !mem_req);

  assert_idle_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_set |-> xfer_done);

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_set && idle_set));

  assert_frame_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind sg_rx_walker sg_rx_walker_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_run(chan_run), .chan_idle(chan_idle),
  .pkt_start(pkt_start), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .in_pop(in_pop),
  .halt_set(halt_set), .idle_set(idle_set), .frame_done(frame_done),
  .xfer_done(xfer_done), .xfer_bytes(xfer_bytes)
);

// File: tb/tb_sg_rx_walker.sv
module tb_sg_rx_walker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int PW = 16;
  localparam int CTRL_JUNK = 32'h0C80_0000;
  localparam int NV = 7;
  // l0 l1 l2 plen tail pre | acc cur_idx frame idle halt
  localparam int VEC [NV][11] = '{
    '{ 8,  8,  8, 20, 2, 0,  20, 3, 1, 1, 0},
    '{10, 10, 10,  5, 2, 0,   5, 1, 1, 0, 0},
    '{ 4,  4,  4, 20, 1, 0,   8, 2, 0, 1, 0},
    '{ 6,  0,  6,  9, 2, 0,   9, 3, 1, 1, 0},
    '{ 8,  8,  8, 16, 2, 2,   8, 1, 0, 0, 1},
    '{16,  8,  8, 16, 0, 0,  16, 1, 1, 1, 0},
    '{ 8,  8,  8,  8, 2, 1,   0, 0, 0, 0, 1}
  };

  logic clk = 0, rst_n = 0;
  logic chan_run = 0, chan_idle = 0, pkt_start = 0;
  logic [AW-1:0] cur_ptr_i = 0, tail_ptr_i = 0;
  logic [PW-1:0] pkt_len = 0;
  logic [7:0] in_byte;
  logic in_pop;
  logic uw_valid = 0, uw_last = 0;
  logic [31:0] uw_data = 0;
  logic uw_err;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic [AW-1:0] cur_ptr_o;
  logic busy, halt_set, idle_set, frame_done, xfer_done;
  logic [PW-1:0] xfer_bytes;

  logic [7:0] mem [4096];
  int pidx, reqcnt, cycles;
  int tests = 0, fails = 0;
  logic [31:0] app_exp [5];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign in_byte = 8'hA0 + 8'(pidx);

  sg_rx_walker #(.AW(AW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .chan_run(chan_run), .chan_idle(chan_idle),
    .cur_ptr_i(cur_ptr_i), .tail_ptr_i(tail_ptr_i), .pkt_start(pkt_start),
    .pkt_len(pkt_len), .in_byte(in_byte), .in_pop(in_pop),
    .uw_valid(uw_valid), .uw_data(uw_data), .uw_last(uw_last), .uw_err(uw_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cur_ptr_o(cur_ptr_o), .busy(busy), .halt_set(halt_set),
    .idle_set(idle_set), .frame_done(frame_done), .xfer_done(xfer_done),
    .xfer_bytes(xfer_bytes)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req) reqcnt <= reqcnt + 1;
      if (in_pop) pidx <= pidx + 1;
      if (mem_req && !mem_ack) begin
        mem_rdata <= {mem[{mem_addr[11:2], 2'd3}], mem[{mem_addr[11:2], 2'd2}],
                      mem[{mem_addr[11:2], 2'd1}], mem[{mem_addr[11:2], 2'd0}]};
        if (mem_we)
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[{mem_addr[11:2], 2'(b)}] <= mem_wdata[8*b +: 8];
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wr32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a+b] = v[8*b +: 8];
  endtask

  task automatic build(input int l0, input int l1, input int l2, input int pre);
    int lens [3];
    lens = '{l0, l1, l2};
    for (int a = 0; a < 4096; a++) mem[a] = (a >= 'h400 && a < 'h700) ? 8'hEE : 8'h00;
    for (int i = 0; i < 3; i++) begin
      wr32('h100 + 'h40*i, 32'h100 + 32'h40*(i+1));
      wr32('h100 + 'h40*i + 8, 32'h400 + 32'h100*i);
      wr32('h100 + 'h40*i + 24, 32'(lens[i]) | CTRL_JUNK);
      wr32('h100 + 'h40*i + 28, pre[i] ? 32'h8000_0000 : 32'h0000_0005);
    end
  endtask

  task automatic send_uw(input int n, input logic [31:0] base, input logic exp_err);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      uw_valid = 1; uw_data = base + 32'(k); uw_last = (k == n-1);
    end
    @(negedge clk);
    uw_valid = 0; uw_last = 0;
    check("R10 uw_err", uw_err, exp_err);
    if (!exp_err) for (int k = 0; k < 5; k++) app_exp[k] = base + 32'(k);
  endtask

  task automatic run(input int len, input int tail, output int acc,
                     output int nf, output int ni, output int nh);
    int t = 0;
    nf = 0; ni = 0; nh = 0; acc = -1;
    pidx = 0; reqcnt = 0;
    @(negedge clk);
    cur_ptr_i = 'h100; tail_ptr_i = 'h100 + 'h40*tail;
    pkt_len = PW'(len); pkt_start = 1;
    do begin
      @(negedge clk);
      pkt_start = 0;
      nf += int'(frame_done); ni += int'(idle_set); nh += int'(halt_set);
      t++;
    end while (!xfer_done && t < 3000);
    if (xfer_done) acc = int'(xfer_bytes);
    else check("R9 walk timeout", 0, 1);
  endtask

  task automatic verify_mem(input int l0, input int l1, input int l2,
                            input int plen, input int tail, input int pre);
    int lens [3];
    int rem, off, c;
    bit ok;
    lens = '{l0, l1, l2};
    rem = plen; off = 0;
    for (int i = 0; i < 3; i++) begin
      if (pre[i]) begin
        check("R3 halted desc untouched", rd32('h100 + 'h40*i + 28), 32'h8000_0000);
        break;
      end
      c = (lens[i] < rem) ? lens[i] : rem;
      ok = 1;
      for (int j = 0; j < c; j++)
        if (mem['h400 + 'h100*i + j] != 8'(8'hA0 + off + j)) ok = 0;
      check("R4 payload bytes", ok, 1);
      check("R4/R11 clip guard byte", mem['h400 + 'h100*i + c], 8'hEE);
      off += c; rem -= c;
      check("R5 status", rd32('h100 + 'h40*i + 28),
            32'h8000_0005 | (i == 0 ? 32'h0800_0000 : 0) | (rem == 0 ? 32'h0400_0000 : 0));
      if (rem == 0)
        for (int k = 0; k < 5; k++)
          check("R6 user word", rd32('h100 + 'h40*i + 32 + 4*k), app_exp[k]);
      if (i == tail || rem == 0) break;
    end
  endtask

  initial begin
    int acc, nf, ni, nh;
    cycles = 0; pidx = 0; reqcnt = 0;
    repeat (3) @(negedge clk);
    check("R1 mem_req", mem_req, 0);
    check("R1 busy", busy, 0);
    check("R1 xfer_done", xfer_done, 0);
    check("R1 pulses", {frame_done, halt_set, idle_set, uw_err}, 0);
    rst_n = 1;
    send_uw(5, 32'h1111_0000, 0);
    chan_run = 1;

    for (int v = 0; v < NV; v++) begin
      build(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][5]);
      run(VEC[v][3], VEC[v][4], acc, nf, ni, nh);
      check("R9 bytes accepted", acc, VEC[v][6]);
      check("R7 cur pointer", cur_ptr_o, 'h100 + 'h40*VEC[v][7]);
      check("R8 frame_done count", nf, VEC[v][8]);
      check("R7 idle_set count", ni, VEC[v][9]);
      check("R3 halt_set count", nh, VEC[v][10]);
      verify_mem(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
    end

    // R10: short and long bursts leave words unchanged
    send_uw(3, 32'h2222_0000, 1);
    send_uw(7, 32'h3333_0000, 1);
    build(10, 10, 10, 0);
    run(5, 2, acc, nf, ni, nh);
    check("R10 bytes", acc, 5);
    verify_mem(10, 10, 10, 5, 2, 0);
    send_uw(5, 32'h4444_0000, 0);
    build(10, 10, 10, 0);
    run(5, 2, acc, nf, ni, nh);
    verify_mem(10, 10, 10, 5, 2, 0);

    // R2: refused starts
    build(8, 8, 8, 0);
    chan_run = 0;
    run(8, 2, acc, nf, ni, nh);
    check("R2 not running bytes", acc, 0);
    check("R2 not running requests", reqcnt, 0);
    chan_run = 1; chan_idle = 1;
    run(8, 2, acc, nf, ni, nh);
    check("R2 idle bytes", acc, 0);
    check("R2 idle requests", reqcnt, 0);
    chan_idle = 0;
    run(0, 2, acc, nf, ni, nh);
    check("R2 zero length requests", reqcnt, 0);
    check("R2 buffer untouched", mem['h400], 8'hEE);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule